// File: doc/BRIEF.md
# Wave Instruction Issue Scheduler

This block sits in front of a 32-lane vector SIMD and decides, every cycle, which of its resident waves sends a vector instruction down the pipe. Each wave slot presents one instruction descriptor at a time. The descriptor holds a transcendental flag, a width flag (32 or 64 work items), a destination register, two source registers and a 64-bit execution mask. The block grants at most one slot per cycle and reports the issued pass on its issue strobe outputs. It tells the granted slot, through an acknowledge, when its instruction has been fully consumed.

A small per-wave shift register records the destinations of recent passes. Any later pass that reads one of those registers is held back until the result latency has elapsed. Meanwhile, round-robin selection hands the cycle to another ready wave. Transcendental passes go to a quarter-rate side unit. A second transcendental pass waits for that unit, but ordinary passes keep flowing. A 64-wide instruction is sent as a low 32-lane pass and then a high 32-lane pass. A half whose mask bits are all zero is not sent.

The descriptor of a slot must stay stable while its valid bit is high and no acknowledge has been seen. The next descriptor is presented in the cycle after an acknowledge.

Top module: `wis_issue_sched`

## Requirements
- R1: At most one pass is issued per cycle. At most one acknowledge is high per cycle, and an issued pass always belongs to a slot whose valid bit is high.
- R2: Selection is round-robin over slot indices. After reset the search starts at slot 0. After any grant it starts at the granted index plus one, wrapping from the last slot to slot 0.
- R3: A pass whose source matches the destination of an earlier pass of the same wave and the same half is held. That earlier pass must have issued 1 to LATENCY-1 cycles before. The dependent pass may issue exactly LATENCY cycles after the producer (5 by default).
- R4: While a wave is held by R3 or R5, any other ready wave is granted in that cycle.
- R5: Two transcendental passes are at least TRANS_RATE cycles apart (4 by default), and `iss_trans` marks every transcendental pass.
- R6: Non-transcendental passes from other waves issue in the cycles while the transcendental unit is busy.
- R7: A 64-wide instruction issues its low pass first and its high pass after it, both with the same destination. `iss_half` is 0 for the low pass and 1 for the high pass. The mask is exec[31:0] for the low pass and exec[63:32] for the high pass. The acknowledge comes with the last pass that is sent.
- R8: A half of a 64-wide instruction whose 32 mask bits are all zero is not issued. If both halves are zero, the grant cycle produces an acknowledge with no issue.
- R9: While reset is low, no pass issues and no acknowledge is given, even with valid descriptors present. Reset clears all pending destinations and frees the transcendental unit.
- R10: A 32-wide instruction issues as a single pass with `iss_half` 0 and mask exec[31:0], and it is acknowledged in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wv_valid | input | NUM_WAVES | Slot holds a descriptor |
| wv_trans | input | NUM_WAVES | Descriptor is a transcendental operation |
| wv_wide | input | NUM_WAVES | Descriptor belongs to a 64-wide wave |
| wv_dst | input | NUM_WAVES x REG_W | Destination register per slot |
| wv_src0 | input | NUM_WAVES x REG_W | First source register per slot |
| wv_src1 | input | NUM_WAVES x REG_W | Second source register per slot |
| wv_exec | input | NUM_WAVES x 64 | Execution mask per slot |
| wv_ack | output | NUM_WAVES | Descriptor consumed this cycle |
| iss_valid | output | 1 | A pass is issued this cycle |
| iss_wave | output | clog2(NUM_WAVES) | Slot of the issued pass |
| iss_half | output | 1 | 0 low pass, 1 high pass |
| iss_trans | output | 1 | Issued pass goes to the transcendental unit |
| iss_dst | output | REG_W | Destination of the issued pass |
| iss_mask | output | 32 | Lane mask of the issued pass |

## Verification
The checker watches several properties on every cycle:
- acknowledge one-hotness and the validity of the issuing slot;
- the non-zero lane mask of every wide pass;
- the single-pass form of narrow instructions;
- the absence of back-to-back transcendental passes;
- the absence of a same-half read of the destination issued one cycle earlier.

The exact stall length of a dependency, the round-robin order with wrap-around, slot filling during a stall, the low-then-high sequence and the all-zero acknowledge can only be shown by the bench. It runs directed scenarios and compares each issue against a cycle-stamped expectation.

// File: rtl/wis_pkg.sv
package wis_pkg;
   localparam int HALF_LANES = 32;
   typedef enum logic [1:0] {
      PASS_NONE = 2'd0,
      PASS_LO   = 2'd1,
      PASS_HI   = 2'd2
   } pass_e;
endpackage

// File: rtl/wis_hazard.sv
module wis_hazard #(
   parameter int LATENCY = 5,
   parameter int REG_W   = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ins_en,
   input  logic             ins_half,
   input  logic [REG_W-1:0] ins_dst,
   input  logic             chk_half,
   input  logic [REG_W-1:0] chk_src0,
   input  logic [REG_W-1:0] chk_src1,
   output logic             hazard
);
   localparam int STAGES = LATENCY - 1;

   if (STAGES == 0) begin : g_nolat
      logic unused_in;
      assign unused_in = ^{clk, rst_n, ins_en, ins_half, ins_dst, chk_half, chk_src0, chk_src1};
      assign hazard = 1'b0;
   end else begin : g_line
      logic [STAGES-1:0]            st_v;
      logic [STAGES-1:0]            st_h;
      logic [STAGES-1:0][REG_W-1:0] st_d;

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            st_v <= '0;
            st_h <= '0;
            st_d <= '0;
         end else begin
            st_v[0] <= ins_en;
            st_h[0] <= ins_half;
            st_d[0] <= ins_dst;
            for (int i = 1; i < STAGES; i++) begin
               st_v[i] <= st_v[i-1];
               st_h[i] <= st_h[i-1];
               st_d[i] <= st_d[i-1];
            end
         end
      end

      always_comb begin
         hazard = 1'b0;
         for (int i = 0; i < STAGES; i++) begin
            if (st_v[i] && (st_h[i] == chk_half) &&
                ((st_d[i] == chk_src0) || (st_d[i] == chk_src1)))
               hazard = 1'b1;
         end
      end
   end
endmodule

// File: rtl/wis_rr_arb.sv
module wis_rr_arb #(
   parameter int N = 20
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [N-1:0]         req,
   output logic                 any,
   output logic [$clog2(N)-1:0] gnt_idx
);
   localparam int IW = $clog2(N);
   logic [IW-1:0] ptr;

   always_comb begin
      any     = 1'b0;
      gnt_idx = '0;
      for (int k = 0; k < N; k++) begin
         int j;
         j = (int'(ptr) + k) % N;
         if (!any && req[j]) begin
            any     = 1'b1;
            gnt_idx = IW'(j);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         ptr <= '0;
      else if (any)
         ptr <= (gnt_idx == IW'(N-1)) ? '0 : gnt_idx + 1'b1;
   end
endmodule

// File: rtl/wis_trans_gate.sv
module wis_trans_gate #(
   parameter int RATE = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic take,
   output logic free
);
   if (RATE <= 1) begin : g_full
      logic unused_in;
      assign unused_in = ^{clk, rst_n, take};
      assign free = 1'b1;
   end else begin : g_slow
      localparam int CW = $clog2(RATE);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
         if (!rst_n)
            cnt <= '0;
         else if (take)
            cnt <= CW'(RATE - 1);
         else if (cnt != '0)
            cnt <= cnt - 1'b1;
      end
      assign free = (cnt == '0);
   end
endmodule

// File: rtl/wis_issue_sched.sv
module wis_issue_sched
   import wis_pkg::*;
#(
   parameter int NUM_WAVES  = 20,
   parameter int REG_W      = 8,
   parameter int LATENCY    = 5,
   parameter int TRANS_RATE = 4
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic [NUM_WAVES-1:0]                 wv_valid,
   input  logic [NUM_WAVES-1:0]                 wv_trans,
   input  logic [NUM_WAVES-1:0]                 wv_wide,
   input  logic [NUM_WAVES-1:0][REG_W-1:0]      wv_dst,
   input  logic [NUM_WAVES-1:0][REG_W-1:0]      wv_src0,
   input  logic [NUM_WAVES-1:0][REG_W-1:0]      wv_src1,
   input  logic [NUM_WAVES-1:0][63:0]           wv_exec,
   output logic [NUM_WAVES-1:0]                 wv_ack,
   output logic                                 iss_valid,
   output logic [$clog2(NUM_WAVES)-1:0]         iss_wave,
   output logic                                 iss_half,
   output logic                                 iss_trans,
   output logic [REG_W-1:0]                     iss_dst,
   output logic [HALF_LANES-1:0]                iss_mask
);
   localparam int IW = $clog2(NUM_WAVES);

   if (NUM_WAVES < 2) begin : g_bad_waves
      $error("wis_issue_sched: NUM_WAVES must be at least 2");
   end
   if (LATENCY < 1) begin : g_bad_lat
      $error("wis_issue_sched: LATENCY must be at least 1");
   end
   if (TRANS_RATE < 1) begin : g_bad_rate
      $error("wis_issue_sched: TRANS_RATE must be at least 1");
   end

   pass_e [NUM_WAVES-1:0] pass;
   logic  [NUM_WAVES-1:0] hi_ph, last, haz, ready, lo_nz, hi_nz;
   logic                  tfree, any;
   logic  [IW-1:0]        gidx;
   pass_e                 gpass;

   for (genvar w = 0; w < NUM_WAVES; w++) begin : g_wave
      assign lo_nz[w] = |wv_exec[w][31:0];
      assign hi_nz[w] = |wv_exec[w][63:32];

      always_comb begin
         if (!wv_wide[w])     pass[w] = PASS_LO;
         else if (hi_ph[w])   pass[w] = PASS_HI;
         else if (lo_nz[w])   pass[w] = PASS_LO;
         else if (hi_nz[w])   pass[w] = PASS_HI;
         else                 pass[w] = PASS_NONE;
      end

      assign last[w] = !wv_wide[w] || (pass[w] != PASS_LO) || !hi_nz[w];

      wis_hazard #(.LATENCY(LATENCY), .REG_W(REG_W)) u_haz (
         .clk      (clk),
         .rst_n    (rst_n),
         .ins_en   (iss_valid && (gidx == IW'(w))),
         .ins_half (iss_half),
         .ins_dst  (wv_dst[w]),
         .chk_half (pass[w] == PASS_HI),
         .chk_src0 (wv_src0[w]),
         .chk_src1 (wv_src1[w]),
         .hazard   (haz[w])
      );

      assign ready[w] = rst_n && wv_valid[w] &&
                        ((pass[w] == PASS_NONE) || (!haz[w] && (!wv_trans[w] || tfree)));

      assign wv_ack[w] = any && (gidx == IW'(w)) && last[w];

      always_ff @(posedge clk) begin
         if (!rst_n)
            hi_ph[w] <= 1'b0;
         else if (any && (gidx == IW'(w))) begin
            if (pass[w] == PASS_HI)
               hi_ph[w] <= 1'b0;
            else if (pass[w] == PASS_LO && wv_wide[w] && hi_nz[w])
               hi_ph[w] <= 1'b1;
         end
      end
   end

   wis_rr_arb #(.N(NUM_WAVES)) u_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (ready),
      .any     (any),
      .gnt_idx (gidx)
   );

   wis_trans_gate #(.RATE(TRANS_RATE)) u_tg (
      .clk   (clk),
      .rst_n (rst_n),
      .take  (iss_valid && iss_trans),
      .free  (tfree)
   );

   assign gpass     = pass[gidx];
   assign iss_valid = any && (gpass != PASS_NONE);
   assign iss_wave  = gidx;
   assign iss_half  = (gpass == PASS_HI);
   assign iss_trans = iss_valid && wv_trans[gidx];
   assign iss_dst   = wv_dst[gidx];
   assign iss_mask  = iss_half ? wv_exec[gidx][63:32] : wv_exec[gidx][31:0];
endmodule

// File: rtl/wis_issue_chk.sv
module wis_issue_chk #(
   parameter int NUM_WAVES = 20,
   parameter int REG_W     = 8,
   parameter int LATENCY   = 5
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic [NUM_WAVES-1:0]            wv_valid,
   input logic [NUM_WAVES-1:0]            wv_wide,
   input logic [NUM_WAVES-1:0][REG_W-1:0] wv_src0,
   input logic [NUM_WAVES-1:0][REG_W-1:0] wv_src1,
   input logic [NUM_WAVES-1:0]            wv_ack,
   input logic                            iss_valid,
   input logic [$clog2(NUM_WAVES)-1:0]    iss_wave,
   input logic                            iss_half,
   input logic                            iss_trans,
   input logic [REG_W-1:0]                iss_dst,
   input logic [31:0]                     iss_mask
);
   p_one_ack_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wv_ack));

   p_issue_from_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid |-> wv_valid[iss_wave]);

   p_wide_mask_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && wv_wide[iss_wave]) |-> (iss_mask != '0));

   p_narrow_low_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && !wv_wide[iss_wave]) |-> (!iss_half && wv_ack[iss_wave]));

   p_trans_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && iss_trans) |=> !(iss_valid && iss_trans));

   if (LATENCY > 1) begin : g_dep
      p_dep_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (iss_valid && $past(iss_valid) && ($past(iss_wave) == iss_wave) &&
          ($past(iss_half) == iss_half))
         |-> ((wv_src0[iss_wave] != $past(iss_dst)) && (wv_src1[iss_wave] != $past(iss_dst))));
   end
endmodule

bind wis_issue_sched wis_issue_chk #(
   .NUM_WAVES (NUM_WAVES),
   .REG_W     (REG_W),
   .LATENCY   (LATENCY)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wv_valid  (wv_valid),
   .wv_wide   (wv_wide),
   .wv_src0   (wv_src0),
   .wv_src1   (wv_src1),
   .wv_ack    (wv_ack),
   .iss_valid (iss_valid),
   .iss_wave  (iss_wave),
   .iss_half  (iss_half),
   .iss_trans (iss_trans),
   .iss_dst   (iss_dst),
   .iss_mask  (iss_mask)
);

// File: tb/sim_wis_issue_sched.sv
`timescale 1ns/1ps
module sim_wis_issue_sched;
   localparam int NW  = 20;
   localparam int RW  = 8;
   localparam int IW  = $clog2(NW);
   localparam int MAXP = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic [NW-1:0]          wv_valid, wv_trans, wv_wide, wv_ack;
   logic [NW-1:0][RW-1:0]  wv_dst, wv_src0, wv_src1;
   logic [NW-1:0][63:0]    wv_exec;
   logic                   iss_valid, iss_half, iss_trans;
   logic [IW-1:0]          iss_wave;
   logic [RW-1:0]          iss_dst;
   logic [31:0]            iss_mask;

   wis_issue_sched u0 (
      .clk(clk), .rst_n(rst_n),
      .wv_valid(wv_valid), .wv_trans(wv_trans), .wv_wide(wv_wide),
      .wv_dst(wv_dst), .wv_src0(wv_src0), .wv_src1(wv_src1), .wv_exec(wv_exec),
      .wv_ack(wv_ack), .iss_valid(iss_valid), .iss_wave(iss_wave),
      .iss_half(iss_half), .iss_trans(iss_trans), .iss_dst(iss_dst), .iss_mask(iss_mask)
   );

   // per-slot programs
   logic        p_tr [NW][MAXP];
   logic        p_wd [NW][MAXP];
   logic [RW-1:0] p_d [NW][MAXP];
   logic [RW-1:0] p_a [NW][MAXP];
   logic [RW-1:0] p_b [NW][MAXP];
   logic [63:0] p_x [NW][MAXP];
   int          p_cnt [NW];
   int          p_idx [NW];

   always_comb begin
      for (int w = 0; w < NW; w++) begin
         int k;
         k = p_idx[w];
         wv_valid[w] = (k < p_cnt[w]);
         if (k < p_cnt[w]) begin
            wv_trans[w] = p_tr[w][k]; wv_wide[w] = p_wd[w][k];
            wv_dst[w] = p_d[w][k]; wv_src0[w] = p_a[w][k];
            wv_src1[w] = p_b[w][k]; wv_exec[w] = p_x[w][k];
         end else begin
            wv_trans[w] = 1'b0; wv_wide[w] = 1'b0; wv_dst[w] = '0;
            wv_src0[w] = '0; wv_src1[w] = '0; wv_exec[w] = '0;
         end
      end
   end

   typedef struct {
      int cyc; int wave; bit half; bit trans; int dst; logic [31:0] mask; string req;
   } exp_t;
   exp_t exq[$];

   int checks = 0, errors = 0, cyc = 0;
   bit run_on = 0, done = 0;

   task automatic clear_progs();
      for (int w = 0; w < NW; w++) begin p_cnt[w] = 0; p_idx[w] = 0; end
   endtask

   task automatic add_ins(int w, bit tr, bit wd, int d, int a, int b, logic [63:0] x);
      int k;
      k = p_cnt[w];
      p_tr[w][k] = tr; p_wd[w][k] = wd; p_d[w][k] = RW'(d);
      p_a[w][k] = RW'(a); p_b[w][k] = RW'(b); p_x[w][k] = x;
      p_cnt[w] = k + 1;
   endtask

   task automatic expect_iss(int c, int w, bit h, bit tr, int d, logic [31:0] m, string req);
      exp_t e;
      e.cyc = c; e.wave = w; e.half = h; e.trans = tr; e.dst = d; e.mask = m; e.req = req;
      exq.push_back(e);
   endtask

   // monitor: compares issues against expectations, advances programs on ack
   initial begin
      forever begin
         logic [NW-1:0] ack_s;
         @(negedge clk);
         ack_s = wv_ack;
         if (run_on && iss_valid) begin
            checks++;
            if (exq.size() == 0) begin
               errors++;
               $display("FAIL unexpected issue cyc=%0d wave=%0d half=%0d (expected none)",
                        cyc, iss_wave, iss_half);
            end else begin
               exp_t e;
               e = exq.pop_front();
               if (e.cyc != cyc || e.wave != int'(iss_wave) || e.half != iss_half ||
                   e.trans != iss_trans || e.dst != int'(iss_dst) || e.mask != iss_mask) begin
                  errors++;
                  $display("FAIL %s actual cyc=%0d wave=%0d half=%0d trans=%0d dst=%0d mask=%h expected cyc=%0d wave=%0d half=%0d trans=%0d dst=%0d mask=%h",
                     e.req, cyc, iss_wave, iss_half, iss_trans, iss_dst, iss_mask,
                     e.cyc, e.wave, e.half, e.trans, e.dst, e.mask);
               end
            end
         end
         @(posedge clk);
         #1;
         if (run_on) begin
            for (int w = 0; w < NW; w++) if (ack_s[w]) p_idx[w]++;
            cyc++;
         end
      end
   end

   task automatic start_scn();
      rst_n = 1'b0;
      repeat (2) @(posedge clk);
      @(negedge clk);
      checks++;
      if (iss_valid !== 1'b0 || wv_ack !== '0) begin
         errors++;
         $display("FAIL R9 actual iss_valid=%b ack=%h expected iss_valid=0 ack=0", iss_valid, wv_ack);
      end
      @(posedge clk);
      #2;
      rst_n = 1'b1;
      cyc = 0;
      run_on = 1;
   endtask

   task automatic end_scn(int n, string req);
      repeat (n) @(posedge clk);
      #3;
      run_on = 0;
      checks++;
      if (exq.size() != 0) begin
         errors++;
         $display("FAIL %s actual %0d issues missing expected 0", req, exq.size());
         exq.delete();
      end
   endtask

   localparam logic [63:0] ALL = 64'hFFFF_FFFF_FFFF_FFFF;

   initial begin
      clear_progs();
      // S1: R2 round-robin with wrap, R1, R10 narrow passes
      add_ins(0, 0, 0, 40, 1, 2, ALL);  add_ins(0, 0, 0, 41, 1, 2, ALL);
      add_ins(1, 0, 0, 50, 1, 2, 64'h0);  add_ins(1, 0, 0, 51, 1, 2, ALL);
      add_ins(19, 0, 0, 60, 1, 2, ALL); add_ins(19, 0, 0, 61, 1, 2, 64'hAAAA_0000_1234_5678);
      expect_iss(0, 0, 0, 0, 40, 32'hFFFFFFFF, "R2");
      expect_iss(1, 1, 0, 0, 50, 32'h0, "R10");
      expect_iss(2, 19, 0, 0, 60, 32'hFFFFFFFF, "R2");
      expect_iss(3, 0, 0, 0, 41, 32'hFFFFFFFF, "R2");
      expect_iss(4, 1, 0, 0, 51, 32'hFFFFFFFF, "R1");
      expect_iss(5, 19, 0, 0, 61, 32'h12345678, "R10");
      start_scn();
      end_scn(12, "R2");

      // S2: R3 dependency stall of LATENCY cycles, R4 fill by another wave
      clear_progs();
      add_ins(0, 0, 0, 5, 1, 2, ALL); add_ins(0, 0, 0, 6, 3, 5, ALL);
      add_ins(1, 0, 0, 20, 30, 31, ALL); add_ins(1, 0, 0, 21, 30, 31, ALL);
      add_ins(1, 0, 0, 22, 30, 31, ALL);
      expect_iss(0, 0, 0, 0, 5, 32'hFFFFFFFF, "R3");
      expect_iss(1, 1, 0, 0, 20, 32'hFFFFFFFF, "R4");
      expect_iss(2, 1, 0, 0, 21, 32'hFFFFFFFF, "R4");
      expect_iss(3, 1, 0, 0, 22, 32'hFFFFFFFF, "R4");
      expect_iss(5, 0, 0, 0, 6, 32'hFFFFFFFF, "R3");
      start_scn();
      end_scn(12, "R3");

      // S3: R5 quarter-rate transcendental, R6 co-issue of ordinary ops
      clear_progs();
      add_ins(0, 1, 0, 14, 14, 15, ALL); add_ins(0, 1, 0, 16, 17, 18, ALL);
      add_ins(1, 0, 0, 8, 1, 2, ALL); add_ins(1, 0, 0, 9, 1, 2, ALL);
      add_ins(1, 0, 0, 10, 1, 2, ALL);
      expect_iss(0, 0, 0, 1, 14, 32'hFFFFFFFF, "R5");
      expect_iss(1, 1, 0, 0, 8, 32'hFFFFFFFF, "R6");
      expect_iss(2, 1, 0, 0, 9, 32'hFFFFFFFF, "R6");
      expect_iss(3, 1, 0, 0, 10, 32'hFFFFFFFF, "R6");
      expect_iss(4, 0, 0, 1, 16, 32'hFFFFFFFF, "R5");
      start_scn();
      end_scn(12, "R5");

      // S4: R7 low then high passes, R8 skipped halves and all-zero consume
      clear_progs();
      add_ins(0, 0, 1, 7, 7, 7, 64'hFFFF0000_0000FFFF);
      add_ins(0, 0, 1, 8, 1, 2, 64'h00000F00_00000000);
      add_ins(0, 0, 1, 9, 3, 4, 64'h00000000_000000F0);
      add_ins(0, 0, 1, 10, 3, 4, 64'h0);
      add_ins(0, 0, 0, 11, 5, 6, 64'h12345678_9ABCDEF0);
      expect_iss(0, 0, 0, 0, 7, 32'h0000FFFF, "R7");
      expect_iss(1, 0, 1, 0, 7, 32'hFFFF0000, "R7");
      expect_iss(2, 0, 1, 0, 8, 32'h00000F00, "R8");
      expect_iss(3, 0, 0, 0, 9, 32'h000000F0, "R8");
      expect_iss(5, 0, 0, 0, 11, 32'h9ABCDEF0, "R8");
      start_scn();
      end_scn(12, "R8");

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #2_000_000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual hung expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule